// File: doc/BRIEF.md
# Debug Clock Source Controller

This block generates the processor clock and its complement from a fast system clock. Three sources can be chosen: a square wave whose half-period is loaded from an input, a fixed-rate square wave set by a parameter, and a manual single-step pulse. The single-step pulse comes from a push-button input that may bounce. A two-flop synchronizer feeds a one-shot that fires once on the first rising level and ignores everything else until its window closes. The default window stands for roughly a quarter of a second of system-clock cycles.

The selected source is gated by a halt line driven by the processor, for example from a breakpoint instruction. An operator override re-opens the gate, so that the halting instruction can be stepped past by hand. Source changes are registered and take effect only while both the old and the new source are low, so no high phase is ever cut short by a switch.

Top module: `debug_clock_ctrl`

## Requirements
- R1: After reset, `cpu_clk_o` is 0, `cpu_clk_n_o` is 1 and the adjustable source (select code 0) is in use.
- R2: On the adjustable source, each high phase and each low phase of `cpu_clk_o` lasts `rate_half_i` system-clock cycles; a value of 0 is treated as 1.
- R3: A new `rate_half_i` is taken only when a low phase ends, so the phase in progress and the low phase that follows it keep the old length.
- R4: On the fixed source (select code 1), each high and low phase lasts `FIX_HALF` cycles.
- R5: On the step source (select code 2), a rising level on `step_btn_i` gives exactly one high phase of `PULSE_CYCLES` cycles. This phase is seen on `cpu_clk_o` 4 cycles after the input changes: two synchronizer flops, the one-shot and the output register.
- R6: Button transitions during the pulse are ignored, and a button still held after the pulse gives no new pulse. A new pulse needs the synchronized button to be seen low after the pulse has ended.
- R7: `cpu_clk_o` is the selected source ANDed with (NOT `halt_i` OR `override_i`), registered with one cycle of delay.
- R8: `cpu_clk_n_o` is always the inverse of `cpu_clk_o`.
- R9: Select code 3 is ignored. A valid new code takes effect only in a cycle where both the current and the requested source are low, so every high phase on the output has the full length of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_half_i | input | HALF_W | Half-period of the adjustable source, in cycles |
| src_sel_i | input | 2 | Requested source: 0 adjustable, 1 fixed, 2 step, 3 ignored |
| step_btn_i | input | 1 | Raw, possibly bouncing, step push-button |
| halt_i | input | 1 | Halt request from the processor |
| override_i | input | 1 | Operator override of the halt |
| cpu_clk_o | output | 1 | Gated processor clock |
| cpu_clk_n_o | output | 1 | Inverse of the processor clock |

## Verification
The bench builds the block with `HALF_W` = 4, `FIX_HALF` = 3 and `PULSE_CYCLES` = 5. With these values every adjustable half-period from 0 to 15 can be swept in full. A step pulse also fits inside a short window, so a bouncing press, a held button and re-arming can each be timed to the exact cycle. The short periods also put source switches, a rate change in the middle of a period and halt/override gating close together, so each run-length check covers several whole periods.

// File: rtl/dbgclk_pkg.sv
package dbgclk_pkg;

    typedef enum logic [1:0] {
        SRC_ADJ   = 2'd0,
        SRC_FIXED = 2'd1,
        SRC_STEP  = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic clk;
        logic clk_n;
    } top_state_t;

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] half_i,
    output logic         level_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] half;
        logic         lvl;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W-1:0] eff_half;

    always_comb begin
        eff_half = (half_i == '0) ? W'(1) : half_i;
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.lvl = ~st_q.lvl;
            if (!st_q.lvl) begin
                // low phase ends: a full period is complete, take new rate
                st_d.half = eff_half;
                st_d.cnt  = eff_half - W'(1);
            end else begin
                st_d.cnt  = st_q.half - W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.half <= W'(1);
            st_q.lvl  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < st_q.half);

    a_r3_reload_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.half) |-> $past(!st_q.lvl && st_q.cnt == '0));

endmodule

// File: rtl/step_oneshot.sv
module step_oneshot #(
    parameter int PULSE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_i,
    output logic pulse_o
);
    localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          armed;
        logic          pulse;
        logic [CW-1:0] cnt;
    } os_state_t;

    os_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = btn_i;
        st_d.sync = st_q.meta;
        if (st_q.pulse) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end else if (st_q.armed && st_q.sync) begin
            st_d.pulse = 1'b1;
            st_d.armed = 1'b0;
            st_d.cnt   = CW'(PULSE_CYCLES - 1);
        end else if (!st_q.sync) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    a_r5_fire_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pulse) |-> $past(st_q.armed && st_q.sync));

    a_r6_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (st_q.pulse && st_q.cnt != '0) |=> st_q.pulse);

    a_r6_no_rearm_in_pulse: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> !st_q.armed);

endmodule

// File: rtl/debug_clock_ctrl.sv
module debug_clock_ctrl
    import dbgclk_pkg::*;
#(
    parameter int HALF_W       = 16,
    parameter int FIX_HALF     = 27,
    parameter int PULSE_CYCLES = 24_200_000
) (
    input  logic              sys_clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] rate_half_i,
    input  logic [1:0]        src_sel_i,
    input  logic              step_btn_i,
    input  logic              halt_i,
    input  logic              override_i,
    output logic              cpu_clk_o,
    output logic              cpu_clk_n_o
);
    localparam int FIX_W = $clog2(FIX_HALF + 1);

    logic [2:0] lvl;    // index by source code
    logic       cur_lvl;
    logic       req_lvl;
    logic       gate_open;
    src_e       req_src;

    top_state_t st_d, st_q;

    rate_divider #(.W(HALF_W)) u_adj (
        .clk     (sys_clk),
        .rst     (rst),
        .half_i  (rate_half_i),
        .level_o (lvl[0])
    );

    rate_divider #(.W(FIX_W)) u_fix (
        .clk     (sys_clk),
        .rst     (rst),
        .half_i  (FIX_W'(FIX_HALF)),
        .level_o (lvl[1])
    );

    step_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_step (
        .clk     (sys_clk),
        .rst     (rst),
        .btn_i   (step_btn_i),
        .pulse_o (lvl[2])
    );

    always_comb begin
        req_src   = src_e'(src_sel_i);
        cur_lvl   = (st_q.src == SRC_NONE) ? 1'b0 : lvl[st_q.src];
        req_lvl   = (req_src == SRC_NONE) ? 1'b0 : lvl[req_src];
        gate_open = !halt_i || override_i;

        st_d = st_q;
        if (req_src != SRC_NONE && req_src != st_q.src && !cur_lvl && !req_lvl) begin
            st_d.src = req_src;
        end
        st_d.clk   = cur_lvl && gate_open;
        st_d.clk_n = !(cur_lvl && gate_open);
    end

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            st_q.src   <= SRC_ADJ;
            st_q.clk   <= 1'b0;
            st_q.clk_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_clk_o   = st_q.clk;
    assign cpu_clk_n_o = st_q.clk_n;

    a_r7_halt_blocks: assert property (@(posedge sys_clk) disable iff (rst)
        $past(halt_i && !override_i) |-> !cpu_clk_o);

    a_r8_complement: assert property (@(posedge sys_clk) disable iff (rst)
        cpu_clk_n_o == !cpu_clk_o);

    a_r9_switch_when_quiet: assert property (@(posedge sys_clk) disable iff (rst)
        !$stable(st_q.src) |-> $past(!cur_lvl && !req_lvl));

    a_r9_never_reserved: assert property (@(posedge sys_clk) disable iff (rst)
        st_q.src != SRC_NONE);

endmodule

// File: tb/sim_debug_clock_ctrl.sv
module sim_debug_clock_ctrl;
    localparam int HALF_W = 4;
    localparam int FIX_HALF = 3;
    localparam int PULSE = 5;

    logic              sys_clk = 1'b0;
    logic              rst = 1'b1;
    logic [HALF_W-1:0] rate_half_i = '0;
    logic [1:0]        src_sel_i = 2'd0;
    logic              step_btn_i = 1'b0;
    logic              halt_i = 1'b0;
    logic              override_i = 1'b0;
    logic              cpu_clk_o;
    logic              cpu_clk_n_o;

    int tests = 0;
    int fails = 0;
    int comp_err = 0;
    bit done = 0;

    logic win [0:511];
    int rl[$];
    bit rv[$];

    always #2 sys_clk = ~sys_clk;

    debug_clock_ctrl #(
        .HALF_W(HALF_W), .FIX_HALF(FIX_HALF), .PULSE_CYCLES(PULSE)
    ) u0 (
        .sys_clk(sys_clk), .rst(rst), .rate_half_i(rate_half_i),
        .src_sel_i(src_sel_i), .step_btn_i(step_btn_i), .halt_i(halt_i),
        .override_i(override_i), .cpu_clk_o(cpu_clk_o), .cpu_clk_n_o(cpu_clk_n_o)
    );

    always @(negedge sys_clk) begin
        if (!rst && cpu_clk_n_o !== ~cpu_clk_o) comp_err++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    task automatic grab(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge sys_clk);
            win[i] = cpu_clk_o;
        end
        rl.delete();
        rv.delete();
        begin
            logic cur;
            int len;
            bit first;
            cur = win[0]; len = 1; first = 1;
            for (int i = 1; i < n; i++) begin
                if (win[i] == cur) len++;
                else begin
                    if (!first) begin rl.push_back(len); rv.push_back(cur); end
                    first = 0; cur = win[i]; len = 1;
                end
            end
        end
    endtask

    task automatic all_runs(input int exp, input string req);
        int bad;
        bad = -1;
        foreach (rl[k]) if (rl[k] != exp) bad = rl[k];
        check(rl.size() >= 2 && bad < 0, req, (bad < 0) ? rl.size() : bad, exp);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) if (win[i] === 1'b1) highs++;
    endtask

    task automatic press(input bit bounce, output int lat, output int rises, output int highs);
        logic prev;
        lat = -1; rises = 0; highs = 0; prev = 1'b0;
        step_btn_i = 1'b1;
        for (int i = 1; i <= 50; i++) begin
            @(negedge sys_clk);
            if (cpu_clk_o === 1'b1) begin
                highs++;
                if (lat < 0) lat = i;
                if (!prev) rises++;
            end
            prev = cpu_clk_o;
            if (bounce && i <= 4) step_btn_i = (i % 2 == 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lat, rises, highs, bad;
        waitc(4);
        rst = 1'b0;
        @(negedge sys_clk);
        // R1: first cycle after reset
        check(cpu_clk_o === 1'b0 && cpu_clk_n_o === 1'b1, "R1 reset outputs", cpu_clk_o, 0);

        // R2: sweep all half-periods on the adjustable source
        for (int h = 0; h < 16; h++) begin
            rate_half_i = HALF_W'(h);
            waitc(40);
            grab(100);
            all_runs((h == 0) ? 1 : h, $sformatf("R2 adj half %0d", h));
        end

        // R3: change rate during a high phase
        rate_half_i = 4'd6;
        waitc(40);
        do @(negedge sys_clk); while (cpu_clk_o !== 1'b1);
        rate_half_i = 4'd2;
        grab(60);
        bad = -1;
        for (int k = 1; k < rl.size(); k++) if (rl[k] != 2) bad = rl[k];
        check(rl.size() > 3 && rv[0] == 1'b0 && rl[0] == 6, "R3 old low kept", rl[0], 6);
        check(bad < 0, "R3 new rate after boundary", bad, 2);

        // R4: fixed source
        src_sel_i = 2'd1;
        waitc(40);
        grab(60);
        all_runs(FIX_HALF, "R4 fixed");

        // R9: reserved code ignored
        rate_half_i = 4'd5;
        src_sel_i = 2'd3;
        waitc(40);
        grab(60);
        all_runs(FIX_HALF, "R9 reserved code");

        // R9: switch fixed -> adjustable keeps every high phase whole
        rate_half_i = 4'd7;
        src_sel_i = 2'd0;
        grab(150);
        bad = -1;
        foreach (rl[k]) if (rv[k] && rl[k] != 3 && rl[k] != 7) bad = rl[k];
        check(bad < 0, "R9 no runt high on switch", bad, 7);
        check(rl.size() > 2 && rl[rl.size()-1] == 7, "R9 switch lands", rl[rl.size()-1], 7);

        // R7: halt freezes, override reopens
        src_sel_i = 2'd1;
        waitc(40);
        halt_i = 1'b1;
        @(negedge sys_clk);
        grab(40);
        count_high(40, highs);
        check(highs == 0, "R7 halt blocks", highs, 0);
        override_i = 1'b1;
        waitc(4);
        grab(60);
        all_runs(FIX_HALF, "R7 override runs");
        halt_i = 1'b0;
        override_i = 1'b0;

        // R5/R6: step source
        src_sel_i = 2'd2;
        waitc(40);
        grab(20);
        count_high(20, highs);
        check(highs == 0, "R5 step idle low", highs, 0);
        press(1'b1, lat, rises, highs);
        check(lat == 4, "R5 latency", lat, 4);
        check(highs == PULSE, "R5 pulse width", highs, PULSE);
        check(rises == 1, "R6 bounce and hold ignored", rises, 1);
        step_btn_i = 1'b0;
        waitc(10);
        press(1'b0, lat, rises, highs);
        check(rises == 1 && highs == PULSE, "R6 rearm after release", highs, PULSE);
        step_btn_i = 1'b0;
        waitc(10);

        // R7: halt on step source, then override
        halt_i = 1'b1;
        press(1'b0, lat, rises, highs);
        check(highs == 0, "R7 halt blocks step", highs, 0);
        step_btn_i = 1'b0;
        waitc(10);
        override_i = 1'b1;
        press(1'b0, lat, rises, highs);
        check(highs == PULSE, "R7 override steps past halt", highs, PULSE);
        step_btn_i = 1'b0;
        halt_i = 1'b0;
        override_i = 1'b0;
        waitc(10);

        // R8: complement seen every cycle
        check(comp_err == 0, "R8 complement", comp_err, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule